// File: doc/BRIEF.md
# Read Data Timeout Timer with Split Encoding

This block times the read data phase of a memory card host controller. It holds a timeout word whose low byte is passed out as the response timeout and whose upper field sets how many card clock cycles a read data phase may last. It starts counting when a read data phase starts. It stops when the data-done event arrives, or when the count runs out, and in that second case it raises a sticky timeout flag. One card clock cycle is marked by a single-cycle enable pulse from the external divider.

A mode input picks how the upper field is read. In flat mode the whole field is one cycle count. In split mode the three low bits of the field are a coarse multiplier of all-ones-field units, and the remaining bits are a fine count in steps of 8 cycles. Split mode reaches about seven times further. In split mode a data error also ends the transfer at once, because waiting for the longer timeout would stall error recovery. Flat mode does not end the transfer on a data error.

Top module: `rd_data_timeout`

## Requirements
- R1: After reset, `drto_flag`, `busy` and `xfer_end` are 0 and the stored timeout word is all ones, so `rsp_tmo` is all ones.
- R2: A `tmo_wr` strobe stores `tmo_wdata`. Bits [RSP_W-1:0] appear on `rsp_tmo` on the next cycle, and bits [TMO_W-1:RSP_W] form the data timeout field.
- R3: In flat mode (`ext_mode`=0) the field value N is the limit. `drto_flag` rises on the edge of the N-th `card_tick` pulse counted since the start, and stays 0 before it. A limit of 0 behaves as 1.
- R4: In split mode (`ext_mode`=1), with c = field bits [2:0] and f = the remaining upper field bits, the limit is f×8 plus (c−1)×(2^DATA_W−1) when c is nonzero. When c is 0 the coarse term is zero.
- R5: With the whole field set to ones in split mode, the limit is 6×(2^DATA_W−1) + (2^(DATA_W−3)−1)×8. At the 24-bit default field this is 0x6FFFFF2 cycles.
- R6: A `data_done` while busy ends the transfer on the next cycle without setting the flag. This holds even when it comes in the same cycle as the final tick.
- R7: In split mode a `data_err` while busy ends the transfer on the next cycle with no flag, and later ticks do not raise it.
- R8: In flat mode `data_err` has no effect: counting goes on and the flag rises at the normal limit.
- R9: `drto_flag` stays set until a `flag_clr` strobe. A clear in the same cycle as an expiry leaves it set.
- R10: A `tmo_wr` or `rd_start` while busy reloads the limit and restarts the count from zero.
- R11: While not busy, `card_tick`, `data_done` and `data_err` have no effect on the count, the flag or `xfer_end`.
- R12: `xfer_end` is a one-cycle pulse on the cycle after each end of a transfer (done, expiry, or error in split mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_wr | input | 1 | Store strobe for the timeout word |
| tmo_wdata | input | TMO_W | Timeout word to store |
| ext_mode | input | 1 | 1 selects the split field reading, 0 the flat one |
| rd_start | input | 1 | Read data phase begins |
| card_tick | input | 1 | One pulse per card clock cycle |
| data_done | input | 1 | Data transfer finished |
| data_err | input | 1 | Data error reported |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| rsp_tmo | output | RSP_W | Response timeout byte of the stored word |
| drto_flag | output | 1 | Sticky data read timeout flag |
| xfer_end | output | 1 | One-cycle pulse when a transfer ends |
| busy | output | 1 | Read data phase being timed |

## Verification
The properties assume that every input is a known synchronous level after reset. They also assume that the mode latched at load or start is the one that governs error handling, so a later change of `ext_mode` mid-transfer is allowed. The end-pulse property holds only when a transfer is not restarted in the same cycle as it ends, and the done and error properties exclude a coincident `rd_start`. The bench drives each strobe for exactly one cycle and changes `ext_mode` only together with a word store. It never starts a transfer in the cycle it ends, so the stimulus stays inside these assumptions.

// File: rtl/rdto_pkg.sv
package rdto_pkg;
  typedef enum logic {
    TMO_FLAT  = 1'b0,
    TMO_SPLIT = 1'b1
  } tmo_mode_e;
endpackage

// File: rtl/rdto_target_decode.sv
module rdto_target_decode
  import rdto_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int COARSE_W = 3,
  parameter bit EXT_EN   = 1'b1,
  parameter int CNT_W    = DATA_W + COARSE_W
) (
  input  logic [DATA_W-1:0] field,
  input  tmo_mode_e         mode,
  output logic [CNT_W-1:0]  target
);
  localparam int FINE_W = DATA_W - COARSE_W;
  localparam logic [CNT_W-1:0] UNIT = CNT_W'({DATA_W{1'b1}});

  logic [CNT_W-1:0] flat_cnt;
  assign flat_cnt = CNT_W'(field);

  generate
    if (EXT_EN) begin : g_split
      logic [COARSE_W-1:0] coarse;
      logic [FINE_W-1:0]   fine;
      logic [CNT_W-1:0]    coarse_part;
      logic [CNT_W-1:0]    fine_part;

      always_comb begin
        coarse = field[COARSE_W-1:0];
        fine   = field[DATA_W-1:COARSE_W];
        // a zero multiplier contributes nothing instead of wrapping
        if (coarse == '0) begin
          coarse_part = '0;
        end else begin
          coarse_part = CNT_W'(coarse - COARSE_W'(1)) * UNIT;
        end
        fine_part = CNT_W'({fine, {COARSE_W{1'b0}}});
        if (mode == TMO_SPLIT) begin
          target = coarse_part + fine_part;
        end else begin
          target = flat_cnt;
        end
      end
    end else begin : g_flat
      tmo_mode_e mode_unused;
      assign mode_unused = mode;
      assign target      = flat_cnt;
    end
  endgenerate
endmodule

// File: rtl/rdto_counter.sv
module rdto_counter #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    hit     = run && tick && (cnt_inc >= {1'b0, target});
    cnt_d   = cnt_q;
    if (clr || hit) begin
      cnt_d = '0;
    end else if (run && tick) begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rdto_ctrl.sv
module rdto_ctrl
  import rdto_pkg::*;
#(
  parameter int TMO_W = 32,
  parameter int RSP_W = 8,
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_wdata,
  input  logic             ext_mode,
  input  logic             rd_start,
  input  logic             data_done,
  input  logic             data_err,
  input  logic             flag_clr,
  input  logic             hit,
  input  logic [CNT_W-1:0] tgt_new,
  output logic [TMO_W-1:0] dec_word,
  output tmo_mode_e        dec_mode,
  output logic [CNT_W-1:0] tgt_q,
  output logic             cnt_clr,
  output logic [RSP_W-1:0] rsp_tmo,
  output logic             busy,
  output logic             drto_flag,
  output logic             xfer_end,
  output logic             split_q
);
  logic [TMO_W-1:0] word_q, word_d;
  logic [CNT_W-1:0] tgt_d;
  logic             busy_q, busy_d;
  logic             flag_q, flag_d;
  logic             end_q, end_d;
  logic             split_d;
  logic             reload;

  assign reload   = tmo_wr || rd_start;
  assign dec_word = tmo_wr ? tmo_wdata : word_q;
  assign dec_mode = tmo_mode_e'(ext_mode);
  assign cnt_clr  = reload;

  always_comb begin
    word_d  = tmo_wr ? tmo_wdata : word_q;
    tgt_d   = reload ? tgt_new : tgt_q;
    split_d = reload ? ext_mode : split_q;
    busy_d  = busy_q;
    flag_d  = flag_q;
    end_d   = 1'b0;
    if (flag_clr) begin
      flag_d = 1'b0;
    end
    if (busy_q) begin
      if (data_done) begin
        busy_d = 1'b0;
        end_d  = 1'b1;
      end else if (hit) begin
        busy_d = 1'b0;
        end_d  = 1'b1;
        flag_d = 1'b1;
      end else if (data_err && split_q) begin
        busy_d = 1'b0;
        end_d  = 1'b1;
      end
    end
    if (rd_start) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '1;
      tgt_q   <= '1;
      split_q <= 1'b0;
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      word_q  <= word_d;
      tgt_q   <= tgt_d;
      split_q <= split_d;
      busy_q  <= busy_d;
      flag_q  <= flag_d;
      end_q   <= end_d;
    end
  end

  assign rsp_tmo   = word_q[RSP_W-1:0];
  assign busy      = busy_q;
  assign drto_flag = flag_q;
  assign xfer_end  = end_q;
endmodule

// File: rtl/rd_data_timeout.sv
module rd_data_timeout
  import rdto_pkg::*;
#(
  parameter int TMO_W    = 32,
  parameter int RSP_W    = 8,
  parameter int COARSE_W = 3,
  parameter bit EXT_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_wdata,
  input  logic             ext_mode,
  input  logic             rd_start,
  input  logic             card_tick,
  input  logic             data_done,
  input  logic             data_err,
  input  logic             flag_clr,
  output logic [RSP_W-1:0] rsp_tmo,
  output logic             drto_flag,
  output logic             xfer_end,
  output logic             busy
);
  localparam int DATA_W = TMO_W - RSP_W;
  localparam int CNT_W  = DATA_W + COARSE_W;

  logic [TMO_W-1:0] dec_word;
  tmo_mode_e        dec_mode;
  logic [CNT_W-1:0] tgt_new;
  logic [CNT_W-1:0] tgt_q;
  logic             cnt_clr;
  logic             hit;
  logic             split_q;

  rdto_ctrl #(
    .TMO_W(TMO_W),
    .RSP_W(RSP_W),
    .CNT_W(CNT_W)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_wr    (tmo_wr),
    .tmo_wdata (tmo_wdata),
    .ext_mode  (ext_mode && EXT_EN),
    .rd_start  (rd_start),
    .data_done (data_done),
    .data_err  (data_err),
    .flag_clr  (flag_clr),
    .hit       (hit),
    .tgt_new   (tgt_new),
    .dec_word  (dec_word),
    .dec_mode  (dec_mode),
    .tgt_q     (tgt_q),
    .cnt_clr   (cnt_clr),
    .rsp_tmo   (rsp_tmo),
    .busy      (busy),
    .drto_flag (drto_flag),
    .xfer_end  (xfer_end),
    .split_q   (split_q)
  );

  rdto_target_decode #(
    .DATA_W  (DATA_W),
    .COARSE_W(COARSE_W),
    .EXT_EN  (EXT_EN),
    .CNT_W   (CNT_W)
  ) i_decode (
    .field  (dec_word[TMO_W-1:RSP_W]),
    .mode   (dec_mode),
    .target (tgt_new)
  );

  rdto_counter #(
    .CNT_W(CNT_W)
  ) i_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .run    (busy),
    .tick   (card_tick),
    .target (tgt_q),
    .hit    (hit)
  );
endmodule

// File: rtl/rdto_checker.sv
module rdto_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_start,
  input logic card_tick,
  input logic data_done,
  input logic data_err,
  input logic flag_clr,
  input logic drto_flag,
  input logic xfer_end,
  input logic busy,
  input logic split_q
);
  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drto_flag && !flag_clr) |=> drto_flag);

  // R6
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_done && !rd_start) |=> (!busy && xfer_end));

  // R6
  done_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_done && !drto_flag) |=> !drto_flag);

  // R7
  split_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_err && split_q && !rd_start) |=> (!busy && xfer_end));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rd_start) |=> (!busy && !xfer_end));

  // R12
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !busy) |=> !xfer_end);

  // R3
  expire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drto_flag) |-> $past(busy && card_tick));
endmodule

bind rd_data_timeout rdto_checker i_rdto_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_start  (rd_start),
  .card_tick (card_tick),
  .data_done (data_done),
  .data_err  (data_err),
  .flag_clr  (flag_clr),
  .drto_flag (drto_flag),
  .xfer_end  (xfer_end),
  .busy      (busy),
  .split_q   (split_q)
);

// File: tb/test_rd_data_timeout.sv
module test_rd_data_timeout;
  localparam int TMO_W = 16;
  localparam int RSP_W = 8;
  localparam int CW    = 3;
  localparam int DW    = TMO_W - RSP_W;
  localparam int UNIT  = (1 << DW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tmo_wr = 1'b0;
  logic [TMO_W-1:0] tmo_wdata = '0;
  logic             ext_mode = 1'b0;
  logic             rd_start = 1'b0;
  logic             card_tick = 1'b0;
  logic             data_done = 1'b0;
  logic             data_err = 1'b0;
  logic             flag_clr = 1'b0;
  logic [RSP_W-1:0] rsp_tmo;
  logic             drto_flag;
  logic             xfer_end;
  logic             busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rd_data_timeout #(
    .TMO_W(TMO_W),
    .RSP_W(RSP_W),
    .COARSE_W(CW)
  ) i_rd_data_timeout (
    .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
    .ext_mode(ext_mode), .rd_start(rd_start), .card_tick(card_tick),
    .data_done(data_done), .data_err(data_err), .flag_clr(flag_clr),
    .rsp_tmo(rsp_tmo), .drto_flag(drto_flag), .xfer_end(xfer_end), .busy(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(bit split, int field);
    int n;
    if (split) begin
      n = ((field % 8) == 0) ? 0 : ((field % 8) - 1) * UNIT;
      n = n + (field >> CW) * 8;
    end else begin
      n = field;
    end
    return (n == 0) ? 1 : n;
  endfunction

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      card_tick = 1'b1;
      @(negedge clk);
      card_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic load(bit split, int field, int low);
    ext_mode  = split;
    tmo_wdata = {field[DW-1:0], low[RSP_W-1:0]};
    tmo_wr    = 1'b1;
    @(negedge clk);
    tmo_wr = 1'b0;
    chk("R2 rsp_tmo", int'(rsp_tmo), low);
  endtask

  task automatic start();
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 flag cleared", int'(drto_flag), 0);
  endtask

  task automatic expire_run(bit split, int field, int gap, string req);
    int n;
    load(split, field, (field ^ 8'h5A) & 8'hFF);
    start();
    n = exp_len(split, field);
    ticks(n - 1, gap);
    chk({req, " busy before limit"}, int'(busy), 1);
    chk({req, " no flag before limit"}, int'(drto_flag), 0);
    ticks(1, 0);
    chk({req, " flag at limit"}, int'(drto_flag), 1);
    chk({req, " idle at limit"}, int'(busy), 0);
    chk("R12 end pulse", int'(xfer_end), 1);
    @(negedge clk);
    chk("R12 end one cycle", int'(xfer_end), 0);
    chk("R9 flag held", int'(drto_flag), 1);
    clear_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flag", int'(drto_flag), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 end", int'(xfer_end), 0);
    chk("R1 rsp_tmo", int'(rsp_tmo), 255);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_tmo after release", int'(rsp_tmo), 255);

    // R3 flat sweep over every field value
    for (int f = 0; f < 256; f++) begin
      expire_run(1'b0, f, ((f % 16) == 3) ? 2 : 0, "R3");
    end

    // R4 split sweep: all coarse values, several fine values
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        int fn;
        fn = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 17 : 30;
        expire_run(1'b1, (fn << CW) | c, (c == 5 && k == 1) ? 1 : 0, "R4");
      end
    end
    // R5 all-ones field in split mode
    chk("R5 max length", exp_len(1'b1, 255), 6 * UNIT + 31 * 8);
    expire_run(1'b1, 255, 0, "R5");

    // R6 done before limit
    load(1'b0, 50, 1);
    start();
    ticks(20, 0);
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    chk("R6 busy after done", int'(busy), 0);
    chk("R6 end after done", int'(xfer_end), 1);
    ticks(60, 0);
    chk("R6 no flag after done", int'(drto_flag), 0);
    // R6 done together with final tick
    load(1'b0, 10, 2);
    start();
    ticks(9, 0);
    card_tick = 1'b1;
    data_done = 1'b1;
    @(negedge clk);
    card_tick = 1'b0;
    data_done = 1'b0;
    chk("R6 same-cycle done no flag", int'(drto_flag), 0);
    chk("R6 same-cycle done ends", int'(busy), 0);

    // R7 split error ends at once
    load(1'b1, (2 << CW) | 2, 3);
    start();
    ticks(5, 0);
    data_err = 1'b1;
    @(negedge clk);
    data_err = 1'b0;
    chk("R7 busy after error", int'(busy), 0);
    chk("R7 end after error", int'(xfer_end), 1);
    ticks(300, 0);
    chk("R7 no flag after error", int'(drto_flag), 0);

    // R8 flat error ignored
    load(1'b0, 20, 4);
    start();
    ticks(3, 0);
    data_err = 1'b1;
    @(negedge clk);
    data_err = 1'b0;
    chk("R8 still busy", int'(busy), 1);
    chk("R8 no end", int'(xfer_end), 0);
    ticks(16, 0);
    chk("R8 no flag yet", int'(drto_flag), 0);
    ticks(1, 0);
    chk("R8 flag at limit", int'(drto_flag), 1);
    clear_flag();

    // R9 clear in same cycle as expiry: set wins
    load(1'b0, 6, 5);
    start();
    ticks(5, 0);
    card_tick = 1'b1;
    flag_clr  = 1'b1;
    @(negedge clk);
    card_tick = 1'b0;
    flag_clr  = 1'b0;
    chk("R9 set beats clear", int'(drto_flag), 1);
    repeat (10) @(negedge clk);
    chk("R9 sticky", int'(drto_flag), 1);
    clear_flag();

    // R10 reload by store while busy
    load(1'b0, 40, 6);
    start();
    ticks(20, 0);
    load(1'b0, 12, 7);
    ticks(11, 0);
    chk("R10 store restart no flag", int'(drto_flag), 0);
    chk("R10 store restart busy", int'(busy), 1);
    ticks(1, 0);
    chk("R10 store restart flag", int'(drto_flag), 1);
    clear_flag();
    // R10 reload by start while busy
    load(1'b0, 30, 8);
    start();
    ticks(25, 0);
    start();
    ticks(29, 0);
    chk("R10 start restart no flag", int'(drto_flag), 0);
    ticks(1, 0);
    chk("R10 start restart flag", int'(drto_flag), 1);
    clear_flag();

    // R11 idle stimuli ignored
    load(1'b0, 5, 9);
    ticks(300, 0);
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    data_err = 1'b1;
    @(negedge clk);
    data_err = 1'b0;
    chk("R11 idle flag", int'(drto_flag), 0);
    chk("R11 idle busy", int'(busy), 0);
    chk("R11 idle end", int'(xfer_end), 0);
    start();
    ticks(4, 0);
    chk("R11 count untouched", int'(drto_flag), 0);
    ticks(1, 0);
    chk("R11 limit after idle", int'(drto_flag), 1);
    clear_flag();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule